// File: doc/BRIEF.md
# Panel Backlight PWM Controller

This block drives a panel backlight through a single pulse-width-modulated pin. Software programs it over a small register port. One control word holds the PWM period in its upper 16 bits and the duty level in its lower 16 bits. A configuration word holds four bits: enable, active-low output, combination mode and level inversion. In combination mode the period is stretched by a factor of 255, and the duty is multiplied by a separate 8-bit legacy brightness byte. This allows a coarse hardware duty and a fine multiplier to share the work. Inversion makes the pin follow the effective maximum minus the programmed level, for panels whose brightness is wired the other way round.

The period counter, duty and period only change at the end of a PWM period, so a register write never cuts a pulse short or adds an extra one. Turning the block off first zeroes the duty and lets the running period finish before the counter stops. Turning it on with a zero duty field fills that field with the period, so the panel comes up at full brightness. A readback address returns the effective brightness level.

Top module: `bl_pwm_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0F420000, the configuration word (address 1) reads 0, and the pin is low.
- R2: A write to address 0 whose period field (bits 31:16) is zero stores the default period 0x0F42 and keeps the written duty (bits 15:0). A nonzero period is stored as written.
- R3: While enabled, the pin is active for exactly `duty` cycles of each `period`-cycle PWM period. Any window of one period length in steady state holds `duty` active cycles.
- R4: A duty equal to or greater than the effective period gives an output that is active on every cycle.
- R5: A duty or period change written in the middle of a PWM period does not affect that period. It takes effect from the next counter wrap.
- R6: With combination mode on (configuration bit 2), the effective period is period×255 cycles and the effective duty is duty×legacy byte (address 2, bits 7:0, reset value 1). Address 3 reads back that effective level.
- R7: With inversion on (configuration bit 3), the active time per period is effective maximum minus effective level, or zero when the level exceeds the maximum. The address 3 readback still returns the level.
- R8: With the active-low bit set (configuration bit 1), the pin is the complement of the active-high waveform, including the idle level high while disabled.
- R9: A write to address 1 that sets the enable bit (bit 0) while the block is disabled and the duty field is zero replaces the duty field with the period. A nonzero duty is kept.
- R10: Clearing the enable bit drives the pin to its inactive level from the second clock edge after the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 configuration, 2 legacy byte, 3 brightness (read-only) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| bl_pwm | output | 1 | Backlight PWM pin |

## Verification
A corrupted counter or shadow register shows at the pin as a wrong count of active cycles within one PWM period of the fault. This is why every duty check counts active cycles over windows of a whole period, rather than looking at single samples. A shadow that reloads at the wrong time shows up in the period that follows a mid-period write. Extra or missing active cycles then appear before the next wrap. Faults in the enable and disable sequencing appear within two clock edges as a pin that is not at its idle level. A bad control register is visible at once on the readback port.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int PER_W   = 16;
    localparam int LEG_W   = 8;
    localparam int CNT_W   = PER_W + LEG_W;
    localparam int WORD_W  = 2 * PER_W;
    localparam int CFG_W   = 4;
    localparam logic [LEG_W-1:0] LEG_SCALE = {LEG_W{1'b1}};

    typedef struct packed {
        logic invert;
        logic combo;
        logic active_low;
        logic enable;
    } cfg_t;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] duty;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } run_state_e;

    function automatic logic [CNT_W-1:0] widen_mul(input logic [PER_W-1:0] a,
                                                   input logic [LEG_W-1:0] b);
        return CNT_W'(a) * CNT_W'(b);
    endfunction
endpackage

// File: rtl/bl_regs.sv
module bl_regs
    import bl_pkg::*;
#(
    parameter logic [PER_W-1:0] DEF_PERIOD = 16'h0F42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl,
    output cfg_t              cfg,
    output logic [LEG_W-1:0]  legacy
);
    ctrl_t wr_ctrl;

    always_comb begin
        wr_ctrl = wdata;
        if (wr_ctrl.period == '0)
            wr_ctrl.period = DEF_PERIOD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.period <= DEF_PERIOD;
            ctrl.duty   <= '0;
            cfg         <= '0;
            legacy      <= LEG_W'(1);
        end else if (wr) begin
            case (addr)
                2'd0: ctrl <= wr_ctrl;
                2'd1: begin
                    cfg <= cfg_t'(wdata[CFG_W-1:0]);
                    // bring-up at full brightness when no level was stored
                    if (wdata[0] && !cfg.enable && ctrl.duty == '0)
                        ctrl.duty <= ctrl.period;
                end
                2'd2: legacy <= wdata[LEG_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bl_level_calc.sv
module bl_level_calc
    import bl_pkg::*;
(
    input  ctrl_t             ctrl,
    input  cfg_t              cfg,
    input  logic [LEG_W-1:0]  legacy,
    output logic [CNT_W-1:0]  eff_max,
    output logic [CNT_W-1:0]  eff_level,
    output logic [CNT_W-1:0]  hw_duty
);
    always_comb begin
        if (cfg.combo) begin
            eff_max   = widen_mul(ctrl.period, LEG_SCALE);
            eff_level = widen_mul(ctrl.duty, legacy);
        end else begin
            eff_max   = CNT_W'(ctrl.period);
            eff_level = CNT_W'(ctrl.duty);
        end
        if (!cfg.invert)
            hw_duty = eff_level;
        else if (eff_level >= eff_max)
            hw_duty = '0;
        else
            hw_duty = eff_max - eff_level;
    end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] tgt_period,
    input  logic [CNT_W-1:0] tgt_duty,
    output logic             active,
    output logic             run,
    output logic             stop,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] sh_period,
    output logic [CNT_W-1:0] sh_duty
);
    run_state_e st;
    logic       wrap;

    assign wrap = (cnt == sh_period - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            sh_period <= '0;
            sh_duty   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (enable) begin
                        st        <= ST_RUN;
                        cnt       <= '0;
                        sh_period <= tgt_period;
                        sh_duty   <= tgt_duty;
                    end
                end
                ST_RUN: begin
                    cnt <= wrap ? '0 : cnt + CNT_W'(1);
                    if (!enable) begin
                        st      <= ST_STOP;
                        sh_duty <= '0;
                    end else if (wrap) begin
                        sh_period <= tgt_period;
                        sh_duty   <= tgt_duty;
                    end
                end
                ST_STOP: begin
                    if (wrap) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign active = (st != ST_IDLE) && (cnt < sh_duty);
    assign run    = (st == ST_RUN);
    assign stop   = (st == ST_STOP);
endmodule

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl
    import bl_pkg::*;
#(
    parameter logic [PER_W-1:0] DEF_PERIOD = 16'h0F42
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              bl_pwm
);
    ctrl_t            ctrl_q;
    cfg_t             cfg_q;
    logic [LEG_W-1:0] legacy_q;
    logic [CNT_W-1:0] eff_max, eff_level, hw_duty;
    logic             core_active, core_run, core_stop;
    logic [CNT_W-1:0] core_cnt, core_sh_period, core_sh_duty;
    logic             cfg_en, cfg_pol;
    logic [PER_W-1:0] ctrl_period, ctrl_duty;

    bl_regs #(.DEF_PERIOD(DEF_PERIOD)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .ctrl(ctrl_q), .cfg(cfg_q), .legacy(legacy_q)
    );

    bl_level_calc u_calc (
        .ctrl(ctrl_q), .cfg(cfg_q), .legacy(legacy_q),
        .eff_max(eff_max), .eff_level(eff_level), .hw_duty(hw_duty)
    );

    bl_pwm_core u_core (
        .clk(clk), .rst(rst), .enable(cfg_q.enable),
        .tgt_period(eff_max), .tgt_duty(hw_duty),
        .active(core_active), .run(core_run), .stop(core_stop),
        .cnt(core_cnt), .sh_period(core_sh_period), .sh_duty(core_sh_duty)
    );

    assign cfg_en      = cfg_q.enable;
    assign cfg_pol     = cfg_q.active_low;
    assign ctrl_period = ctrl_q.period;
    assign ctrl_duty   = ctrl_q.duty;
    assign bl_pwm      = core_active ^ cfg_pol;

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = ctrl_q;
            2'd1:    reg_rdata = WORD_W'(cfg_q);
            2'd2:    reg_rdata = WORD_W'(legacy_q);
            default: reg_rdata = WORD_W'(eff_level);
        endcase
    end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
    import bl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             stop,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] sh_period,
    input logic [CNT_W-1:0] sh_duty,
    input logic             pin,
    input logic             active_low,
    input logic             enable,
    input logic [PER_W-1:0] period_f,
    input logic [PER_W-1:0] duty_f
);
    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        period_f != '0); // R2

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (run || stop) |-> cnt < sh_period); // R3

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && cnt != '0) |-> ($stable(sh_duty) && $stable(sh_period))); // R5

    AST_ENABLE_NONZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |-> duty_f != '0); // R9

    AST_OFF_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !run |-> pin == active_low); // R10
endmodule

bind bl_pwm_ctrl bl_pwm_chk u_chk (
    .clk(clk), .rst(rst), .run(core_run), .stop(core_stop), .cnt(core_cnt),
    .sh_period(core_sh_period), .sh_duty(core_sh_duty), .pin(bl_pwm),
    .active_low(cfg_pol), .enable(cfg_en), .period_f(ctrl_period), .duty_f(ctrl_duty)
);

// File: tb/sim_bl_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_bl_pwm_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bl_pwm;
    int          n_checks = 0;
    int          n_fails  = 0;

    bl_pwm_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bl_pwm(bl_pwm)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count_high(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bl_pwm) hits++;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && bl_pwm) break;
            prev = bl_pwm;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 ctrl reset", v, 32'h0F42_0000);
        rd(2'd1, v); check("R1 cfg reset", v, 0);
        check("R1 pin reset", bl_pwm, 0);
    endtask

    task automatic t_default_period();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0033);
        rd(2'd0, v); check("R2 zero period", v, 32'h0F42_0033);
        wr(2'd0, {16'd10, 16'd3});
        rd(2'd0, v); check("R2 written period", v, {16'd10, 16'd3});
    endtask

    task automatic t_basic();
        int h;
        wr(2'd1, 32'h1);
        settle(30);
        count_high(10, h); check("R3 duty 3/10", h, 3);
        count_high(20, h); check("R3 two periods", h, 6);
        wr(2'd0, {16'd10, 16'd7});
        settle(30);
        count_high(10, h); check("R3 duty 7/10", h, 7);
    endtask

    task automatic t_full();
        int h;
        wr(2'd0, {16'd10, 16'd15});
        settle(30);
        count_high(37, h); check("R4 duty above period", h, 37);
        wr(2'd0, {16'd10, 16'd10});
        settle(30);
        count_high(10, h); check("R4 duty equals period", h, 10);
    endtask

    task automatic t_wrap_update();
        int h;
        wr(2'd0, {16'd10, 16'd3});
        settle(30);
        wait_rise();
        count_high(4, h);
        wr(2'd0, {16'd10, 16'd8});
        count_high(3, h); check("R5 rest of period unchanged", h, 0);
        count_high(10, h); check("R5 next period new duty", h, 8);
    endtask

    task automatic t_invert();
        int h;
        logic [31:0] v;
        wr(2'd0, {16'd10, 16'd3});
        wr(2'd1, 32'h9);
        settle(30);
        count_high(10, h); check("R7 inverted 10-3", h, 7);
        wr(2'd0, {16'd10, 16'd12});
        settle(30);
        count_high(10, h); check("R7 inverted saturates", h, 0);
        rd(2'd3, v); check("R7 readback level", v, 12);
    endtask

    task automatic t_combo();
        int h;
        logic [31:0] v;
        wr(2'd0, {16'd4, 16'd2});
        wr(2'd2, 32'd3);
        wr(2'd1, 32'h5);
        settle(2100);
        count_high(1020, h); check("R6 combo duty 2x3 over 1020", h, 6);
        rd(2'd3, v); check("R6 combo level readback", v, 6);
        wr(2'd1, 32'h1);
        settle(1100);
    endtask

    task automatic t_disable();
        int h;
        wr(2'd0, {16'd10, 16'd10});
        settle(30);
        wr(2'd1, 32'h0);
        count_high(20, h); check("R10 pin off after disable", h, 0);
    endtask

    task automatic t_polarity();
        int h;
        wr(2'd0, {16'd10, 16'd3});
        wr(2'd1, 32'h3);
        settle(30);
        count_high(10, h); check("R8 active low waveform", h, 7);
        wr(2'd1, 32'h2);
        count_high(15, h); check("R8 idle level high", h, 15);
        wr(2'd1, 32'h0);
        settle(20);
    endtask

    task automatic t_enable_fill();
        int h;
        logic [31:0] v;
        wr(2'd0, {16'd10, 16'd0});
        settle(5);
        wr(2'd1, 32'h1);
        rd(2'd0, v); check("R9 zero duty filled", v, {16'd10, 16'd10});
        settle(20);
        count_high(10, h); check("R9 full brightness", h, 10);
        wr(2'd1, 32'h0);
        settle(25);
        wr(2'd0, {16'd10, 16'd4});
        wr(2'd1, 32'h1);
        rd(2'd0, v); check("R9 nonzero duty kept", v, {16'd10, 16'd4});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_default_period();
        t_basic();
        t_full();
        t_wrap_update();
        t_invert();
        t_combo();
        t_disable();
        t_polarity();
        t_enable_fill();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule